// File: doc/BRIEF.md
# Flash Self-Programming Command Controller

This block sequences page-oriented self-programming of on-chip program flash. The CPU first writes an 8-bit control register to arm a command, then pulses a program strobe that carries a word address and a 16-bit data word. The address splits into an upper page field and a lower word-in-page field. The controller recognises three commands. A buffer load stores one data word into a temporary page buffer. A page erase and a page write each raise a level request to the flash array model. The request is held until the model returns a one-cycle done pulse.

A command is accepted only if the strobe comes within a short window after the arming write. The page buffer is write-once per word until it is cleared, and it may be filled in any order, either before or after the erase. The page address is captured when a command is accepted. When the captured page lies in the upper, no-read-while-write part of the flash, the CPU is held off for the whole operation. While a command is in progress, the busy flag in the control register reads as set and new commands are refused.

Top module: `flash_selfprog_ctrl`

## Requirements
- R1: A strobe is accepted only if it is sampled on clock edge 1 to 4 after the edge that took an arming control write (bit 0 set, bit 4 clear). A strobe on a later edge has no effect. The armed state reads back on ctl_rdata bit 0.
- R2: The latched control byte is decoded as follows. Exactly 8'h01 is a buffer load. Bits 6:0 equal to 7'h03 is a page erase. Bits 6:0 equal to 7'h05 is a page write. Bit 7 is ignored for erase and write. Every other code does nothing when its strobe arrives.
- R3: Erase and write take their target page from prog_addr[ADDR_W-1:WORD_W] and present it on fl_page. A load takes its word index from prog_addr[WORD_W-1:0] and its data from prog_data.
- R4: Once a buffer word has been loaded, further loads to that word are ignored until the buffer is cleared.
- R5: The buffer clears when a page write completes, on a control write with bit 4 set, and on reset. A word that was never loaded reads as 16'hFFFF on fl_rd_data.
- R6: A pulse on ee_write discards every loaded buffer word.
- R7: The page is captured when the command is accepted. Later changes on prog_addr do not change fl_page while the operation runs.
- R8: cpu_halt is high during an erase or write whose page is at or above NRWW_FIRST. It stays low for lower pages and when no operation runs.
- R9: From the edge that accepts an erase or write, ctl_rdata bit 6 and the matching request stay high until the edge that samples fl_done. At most one request is high at any time.
- R10: While busy, control writes and strobes are ignored. A load attempted during an operation leaves the buffer unchanged.
- R11: Loads are accepted in any word order, both before and after a page erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Status: bit 6 busy, bit 0 armed |
| prog_strobe | input | 1 | Program strobe that fires an armed command |
| prog_addr | input | ADDR_W (7) | Word address: page field above word field |
| prog_data | input | DATA_W (16) | Data word for buffer load |
| ee_write | input | 1 | EEPROM write event; clears the page buffer |
| fl_erase_req | output | 1 | Page erase request to the flash model |
| fl_write_req | output | 1 | Page write request to the flash model |
| fl_page | output | PAGE_W (4) | Captured target page |
| fl_rd_idx | input | WORD_W (3) | Buffer read index used by the flash model |
| fl_rd_data | output | DATA_W (16) | Buffer word at fl_rd_idx, or all ones if not loaded |
| fl_done | input | 1 | One-cycle completion pulse from the flash model |
| cpu_halt | output | 1 | Holds the CPU during no-read-while-write operations |

## Verification
The bench probes both edges of the arming window. A strobe on the fourth edge after the arming write must fire, and one on the fifth must not; an off-by-one counter would either drop a legal command or let a stale one through. A second load to the same word must leave the first value in place; a design that overwrote would silently corrupt a page during read-modify-write. The halt output is checked on the pages just above and just below the region boundary, and fl_page is checked while prog_addr changes mid-operation. The bench also covers the four buffer-clear paths and a load attempted during busy. A design that missed any of these would leave stale words in the buffer or write the wrong page.

// File: rtl/fsp_pkg.sv
package fsp_pkg;

  // control register bit positions
  localparam int ARMED_BIT = 0;
  localparam int GO_BIT    = 0;
  localparam int CLR_BIT   = 4;
  localparam int BUSY_BIT  = 6;

  typedef enum logic [1:0] {
    CMD_NONE  = 2'd0,
    CMD_LOAD  = 2'd1,
    CMD_ERASE = 2'd2,
    CMD_WRITE = 2'd3
  } cmd_kind_t;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_ERASE = 2'd1,
    SEQ_WRITE = 2'd2
  } seq_state_t;

  function automatic cmd_kind_t decode_cmd(input logic [7:0] code);
    cmd_kind_t k;
    if (code == 8'h01)           k = CMD_LOAD;
    else if (code[6:0] == 7'h03) k = CMD_ERASE;
    else if (code[6:0] == 7'h05) k = CMD_WRITE;
    else                         k = CMD_NONE;
    return k;
  endfunction

endpackage

// File: rtl/fsp_arm.sv
module fsp_arm
  import fsp_pkg::*;
#(
  parameter int ARM_WIN = 4,
  localparam int CNT_W  = $clog2(ARM_WIN + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_we,
  input  logic [7:0] ctl_wdata,
  input  logic       busy,
  input  logic       prog_strobe,
  output logic       fire,
  output cmd_kind_t  kind,
  output logic       armed,
  output logic       buf_clr
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [7:0]       code_q, code_d;
  logic             ctl_take;

  assign ctl_take = ctl_we && !busy;
  assign armed    = (cnt_q != '0);
  assign fire     = prog_strobe && !busy && !ctl_take && armed;
  assign kind     = decode_cmd(code_q);
  assign buf_clr  = ctl_take && ctl_wdata[CLR_BIT];

  always_comb begin
    cnt_d  = cnt_q;
    code_d = code_q;
    if (ctl_take) begin
      code_d = ctl_wdata;
      if (ctl_wdata[GO_BIT] && !ctl_wdata[CLR_BIT]) cnt_d = CNT_W'(ARM_WIN);
      else                                           cnt_d = '0;
    end else if (armed) begin
      if (fire) cnt_d = '0;
      else      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      code_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (ctl_take) code_q <= code_d;
    end
  end

endmodule

// File: rtl/fsp_pagebuf.sv
module fsp_pagebuf #(
  parameter int WORD_W = 3,
  parameter int DATA_W = 16,
  localparam int WORDS = 1 << WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [WORD_W-1:0] ld_idx,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              clr,
  input  logic [WORD_W-1:0] rd_idx,
  output logic [DATA_W-1:0] rd_data
);

  logic [WORDS-1:0]  valid_q;
  logic [WORDS-1:0]  valid_d;
  logic [DATA_W-1:0] data_q [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic hit;
    assign hit        = ld_en && (ld_idx == WORD_W'(w)) && !valid_q[w];
    assign valid_d[w] = clr ? 1'b0 : (valid_q[w] || hit);

    always_ff @(posedge clk) begin
      if (hit) data_q[w] <= ld_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  assign rd_data = valid_q[rd_idx] ? data_q[rd_idx] : '1;

endmodule

// File: rtl/fsp_seq.sv
module fsp_seq
  import fsp_pkg::*;
#(
  parameter int PAGE_W     = 4,
  parameter int NRWW_FIRST = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  cmd_kind_t         kind,
  input  logic [PAGE_W-1:0] page_in,
  input  logic              fl_done,
  output logic              erase_req,
  output logic              write_req,
  output logic              busy,
  output logic [PAGE_W-1:0] page,
  output logic              halt,
  output logic              wr_done
);

  seq_state_t        state_q, state_d;
  logic [PAGE_W-1:0] page_q;
  logic              page_en;

  always_comb begin
    state_d = state_q;
    page_en = 1'b0;
    wr_done = 1'b0;
    case (state_q)
      SEQ_IDLE: begin
        if (fire && kind == CMD_ERASE) begin
          state_d = SEQ_ERASE;
          page_en = 1'b1;
        end else if (fire && kind == CMD_WRITE) begin
          state_d = SEQ_WRITE;
          page_en = 1'b1;
        end
      end
      SEQ_ERASE: if (fl_done) state_d = SEQ_IDLE;
      SEQ_WRITE: begin
        if (fl_done) begin
          state_d = SEQ_IDLE;
          wr_done = 1'b1;
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      page_q  <= '0;
    end else begin
      state_q <= state_d;
      if (page_en) page_q <= page_in;
    end
  end

  assign erase_req = (state_q == SEQ_ERASE);
  assign write_req = (state_q == SEQ_WRITE);
  assign busy      = (state_q != SEQ_IDLE);
  assign page      = page_q;
  assign halt      = busy && (page_q >= PAGE_W'(NRWW_FIRST));

endmodule

// File: rtl/flash_selfprog_ctrl.sv
module flash_selfprog_ctrl
  import fsp_pkg::*;
#(
  parameter int PAGE_W     = 4,
  parameter int WORD_W     = 3,
  parameter int DATA_W     = 16,
  parameter int ARM_WIN    = 4,
  parameter int NRWW_FIRST = 12,
  localparam int ADDR_W    = PAGE_W + WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [7:0]        ctl_wdata,
  output logic [7:0]        ctl_rdata,
  input  logic              prog_strobe,
  input  logic [ADDR_W-1:0] prog_addr,
  input  logic [DATA_W-1:0] prog_data,
  input  logic              ee_write,
  output logic              fl_erase_req,
  output logic              fl_write_req,
  output logic [PAGE_W-1:0] fl_page,
  input  logic [WORD_W-1:0] fl_rd_idx,
  output logic [DATA_W-1:0] fl_rd_data,
  input  logic              fl_done,
  output logic              cpu_halt
);

  // reset asserts at once, releases on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic      fire, armed, buf_clr_ctl, busy, wr_done, ld_en, buf_clr;
  cmd_kind_t kind;

  fsp_arm #(.ARM_WIN(ARM_WIN)) u_arm (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .ctl_we      (ctl_we),
    .ctl_wdata   (ctl_wdata),
    .busy        (busy),
    .prog_strobe (prog_strobe),
    .fire        (fire),
    .kind        (kind),
    .armed       (armed),
    .buf_clr     (buf_clr_ctl)
  );

  fsp_seq #(.PAGE_W(PAGE_W), .NRWW_FIRST(NRWW_FIRST)) u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .fire      (fire),
    .kind      (kind),
    .page_in   (prog_addr[ADDR_W-1:WORD_W]),
    .fl_done   (fl_done),
    .erase_req (fl_erase_req),
    .write_req (fl_write_req),
    .busy      (busy),
    .page      (fl_page),
    .halt      (cpu_halt),
    .wr_done   (wr_done)
  );

  assign ld_en   = fire && (kind == CMD_LOAD);
  assign buf_clr = buf_clr_ctl || ee_write || wr_done;

  fsp_pagebuf #(.WORD_W(WORD_W), .DATA_W(DATA_W)) u_buf (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .ld_en   (ld_en),
    .ld_idx  (prog_addr[WORD_W-1:0]),
    .ld_data (prog_data),
    .clr     (buf_clr),
    .rd_idx  (fl_rd_idx),
    .rd_data (fl_rd_data)
  );

  always_comb begin
    ctl_rdata            = '0;
    ctl_rdata[BUSY_BIT]  = busy;
    ctl_rdata[ARMED_BIT] = armed;
  end

endmodule

// File: rtl/fsp_chk.sv
module fsp_chk #(
  parameter int PAGE_W     = 4,
  parameter int ARM_WIN    = 4,
  parameter int NRWW_FIRST = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ctl_we,
  input logic [7:0]        ctl_wdata,
  input logic [7:0]        ctl_rdata,
  input logic              fl_erase_req,
  input logic              fl_write_req,
  input logic              fl_done,
  input logic [PAGE_W-1:0] fl_page,
  input logic              cpu_halt
);

  localparam int WIN_W = $clog2(ARM_WIN + 2) + 1;
  localparam logic [WIN_W-1:0] WIN_SAT = '1;

  logic [WIN_W-1:0] win_q;
  logic             op_on;

  assign op_on = fl_erase_req || fl_write_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      win_q <= WIN_SAT;
    else if (ctl_we && ctl_wdata[0] && !ctl_wdata[4] && !ctl_rdata[6])
      win_q <= '0;
    else if (win_q != WIN_SAT)
      win_q <= win_q + 1'b1;
  end

  // R1
  window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(fl_erase_req) || $rose(fl_write_req)) |-> ($past(win_q) < WIN_W'(ARM_WIN)));

  // R9
  erase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_erase_req && !fl_done) |=> fl_erase_req);

  // R9
  write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_write_req && !fl_done) |=> fl_write_req);

  // R9
  req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fl_erase_req && fl_write_req));

  // R9
  busy_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[6] == op_on);

  // R7
  page_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_on && !fl_done) |=> $stable(fl_page));

  // R8
  halt_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_halt |-> (op_on && fl_page >= PAGE_W'(NRWW_FIRST)));

  // R8
  halt_needed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_on && fl_page >= PAGE_W'(NRWW_FIRST)) |-> cpu_halt);

endmodule

bind flash_selfprog_ctrl fsp_chk #(
  .PAGE_W     (PAGE_W),
  .ARM_WIN    (ARM_WIN),
  .NRWW_FIRST (NRWW_FIRST)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ctl_we       (ctl_we),
  .ctl_wdata    (ctl_wdata),
  .ctl_rdata    (ctl_rdata),
  .fl_erase_req (fl_erase_req),
  .fl_write_req (fl_write_req),
  .fl_done      (fl_done),
  .fl_page      (fl_page),
  .cpu_halt     (cpu_halt)
);

// File: tb/sim_flash_selfprog_ctrl.sv
`timescale 1ns/100ps
module sim_flash_selfprog_ctrl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ctl_we;
  logic [7:0]  ctl_wdata;
  logic [7:0]  ctl_rdata;
  logic        prog_strobe;
  logic [6:0]  prog_addr;
  logic [15:0] prog_data;
  logic        ee_write;
  logic        fl_erase_req, fl_write_req, fl_done, cpu_halt;
  logic [3:0]  fl_page;
  logic [2:0]  fl_rd_idx;
  logic [15:0] fl_rd_data;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  flash_selfprog_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .prog_strobe(prog_strobe), .prog_addr(prog_addr),
    .prog_data(prog_data), .ee_write(ee_write), .fl_erase_req(fl_erase_req),
    .fl_write_req(fl_write_req), .fl_page(fl_page), .fl_rd_idx(fl_rd_idx),
    .fl_rd_data(fl_rd_data), .fl_done(fl_done), .cpu_halt(cpu_halt)
  );

  // kind: 0 nothing, 1 load, 2 erase, 3 write; addr = {page[3:0], word[2:0]}
  typedef struct packed {
    logic [7:0]  code;
    logic [3:0]  gap;
    logic [6:0]  addr;
    logic [15:0] data;
    logic [1:0]  kind;
    logic [15:0] exp;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{8'h01, 4'd1, 7'h13, 16'h1234, 2'd1, 16'h1234},  // R3 load word 3
    '{8'h01, 4'd4, 7'h15, 16'hABCD, 2'd1, 16'hABCD},  // R1 last edge of window
    '{8'h01, 4'd5, 7'h16, 16'h5555, 2'd0, 16'hFFFF},  // R1 one edge late
    '{8'h01, 4'd2, 7'h13, 16'h9999, 2'd1, 16'h1234},  // R4 second load ignored
    '{8'h81, 4'd1, 7'h10, 16'h7777, 2'd0, 16'hFFFF},  // R2 bit 7 spoils load
    '{8'h83, 4'd3, 7'h28, 16'h0000, 2'd2, 16'hFFFF},  // R2 erase, bit 7 ignored
    '{8'h01, 4'd1, 7'h28, 16'h0F0F, 2'd1, 16'h0F0F},  // R11 load after erase
    '{8'h05, 4'd2, 7'h6B, 16'h0000, 2'd3, 16'hFFFF},  // R5 write clears buffer
    '{8'h03, 4'd4, 7'h65, 16'h0000, 2'd2, 16'hFFFF},  // R8 page 12 halts
    '{8'h03, 4'd4, 7'h5D, 16'h0000, 2'd2, 16'hFFFF},  // R8 page 11 runs
    '{8'h07, 4'd1, 7'h1B, 16'h0000, 2'd0, 16'hFFFF},  // R2 unknown code
    '{8'h85, 4'd5, 7'h13, 16'h0000, 2'd0, 16'hFFFF}   // R1 late write
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ctl_write(input logic [7:0] code);
    @(negedge clk);
    ctl_we    = 1'b1;
    ctl_wdata = code;
    @(negedge clk);
    ctl_we    = 1'b0;
  endtask

  // strobe sampled on edge number gap after the edge that took the write
  task automatic issue(input logic [7:0] code, input int gap,
                       input logic [6:0] addr, input logic [15:0] data);
    ctl_write(code);
    repeat (gap - 1) @(negedge clk);
    prog_addr   = addr;
    prog_data   = data;
    prog_strobe = 1'b1;
    @(negedge clk);
    prog_strobe = 1'b0;
  endtask

  task automatic finish_op();
    @(negedge clk);
    fl_done = 1'b1;
    @(negedge clk);
    fl_done = 1'b0;
  endtask

  task automatic read_buf(input string req, input logic [2:0] idx, input logic [15:0] exp);
    fl_rd_idx = idx;
    #0.5;
    chk(req, fl_rd_data, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ctl_we = 1'b0; ctl_wdata = '0; prog_strobe = 1'b0;
    prog_addr = '0; prog_data = '0; ee_write = 1'b0; fl_done = 1'b0; fl_rd_idx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // reset state (R5: empty buffer reads all ones)
    chk("R9 reset status", ctl_rdata, 8'h00);
    chk("R9 reset reqs", {fl_erase_req, fl_write_req}, 2'b00);
    chk("R8 reset halt", cpu_halt, 1'b0);
    read_buf("R5 reset buffer", 3'd0, 16'hFFFF);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      logic [3:0] pg;
      v  = VECS[i];
      pg = v.addr[6:3];
      issue(v.code, int'(v.gap), v.addr, v.data);
      if (v.kind >= 2'd2) begin
        chk("R9 busy set", ctl_rdata[6], 1'b1);
        chk("R2 erase req", fl_erase_req, v.kind == 2'd2);
        chk("R2 write req", fl_write_req, v.kind == 2'd3);
        chk("R3 page", fl_page, pg);
        chk("R8 halt", cpu_halt, pg >= 4'd12);
        repeat (2) @(negedge clk);
        chk("R9 busy held", ctl_rdata[6], 1'b1);
        finish_op();
        chk("R9 busy clear", ctl_rdata[6], 1'b0);
        chk("R8 halt clear", cpu_halt, 1'b0);
      end else begin
        chk("R2 idle reqs", {fl_erase_req, fl_write_req, ctl_rdata[6]}, 3'b000);
      end
      read_buf("R4 buffer word", v.addr[2:0], v.exp);
    end

    // R7: page held though the address moves; R10: load during busy ignored
    issue(8'h03, 1, 7'h20, 16'h0);
    prog_addr = 7'h7F;
    repeat (2) @(negedge clk);
    chk("R7 page held", fl_page, 4'd4);
    chk("R8 low page runs", cpu_halt, 1'b0);
    issue(8'h01, 1, 7'h04, 16'h4444);
    chk("R10 not armed", ctl_rdata[0], 1'b0);
    finish_op();
    read_buf("R10 load while busy", 3'd4, 16'hFFFF);
    chk("R10 idle after", ctl_rdata[6], 1'b0);

    // R5: control write with bit 4 clears the buffer
    issue(8'h01, 1, 7'h01, 16'h1111);
    read_buf("R11 load word 1", 3'd1, 16'h1111);
    ctl_write(8'h10);
    read_buf("R5 bit4 clear", 3'd1, 16'hFFFF);

    // R6: EEPROM write discards loaded data
    issue(8'h01, 1, 7'h02, 16'h2222);
    read_buf("R6 loaded", 3'd2, 16'h2222);
    @(negedge clk); ee_write = 1'b1;
    @(negedge clk); ee_write = 1'b0;
    read_buf("R6 ee clear", 3'd2, 16'hFFFF);

    // R1: armed flag lasts four edges
    ctl_write(8'h01);
    chk("R1 armed", ctl_rdata[0], 1'b1);
    repeat (3) @(negedge clk);
    chk("R1 still armed", ctl_rdata[0], 1'b1);
    @(negedge clk);
    chk("R1 expired", ctl_rdata[0], 1'b0);

    // R5: reset clears the buffer
    issue(8'h01, 1, 7'h06, 16'h6666);
    read_buf("R5 loaded", 3'd6, 16'h6666);
    rst_n = 1'b0;
    @(negedge clk);
    read_buf("R5 reset clear", 3'd6, 16'hFFFF);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 status after reset", ctl_rdata, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule